// File: doc/BRIEF.md
# Per-CPU External Interrupt Mailbox

This block receives interrupts that arrive from an external I/O bus and parks each one in a mailbox owned by the target processor. There are 32 mailboxes, one per CPU. Each holds a busy flag, a 5-bit source id and two 64-bit data words. An arriving interrupt names a target CPU, a source and two data words. If that CPU's mailbox is free, the interrupt is accepted in the same cycle: the block stores it, marks the mailbox busy and raises a post towards the CPU carrying the externally configured 6-bit vector. If the mailbox is still busy, the interrupt is refused and the sender must retry later. A full mailbox therefore pushes back on the sender.

Software uses a 64-bit register port that also carries the CPU id of the requester. It can read the data words and busy status of any mailbox by index. Alias offsets reach the mailbox of whichever CPU performs the access. Software frees a mailbox by writing its busy register. Read data returns one cycle after the request.

Top module: `ext_irq_mailbox`

## Requirements
- R1: After reset every busy flag is clear, every stored source id and data word reads as zero, `post_valid` is low and `irq_ack` is low while `irq_req` is low.
- R2: An interrupt request whose target mailbox is not busy is accepted in the same cycle (`irq_ack` high). From the next cycle the mailbox is busy and holds the request's source id and both data words.
- R3: An interrupt request whose target mailbox is busy is refused (`irq_ack` low). The mailbox keeps its source and data, and no post follows.
- R4: One cycle after an accepted request, `post_valid` is high for exactly one cycle. `post_cpu` equals the target CPU and `post_vec` equals the `ext_vec` value present when the request was accepted.
- R5: A read at offset 0x400 + 8*n returns first data word n, and a read at offset 0x500 + 8*n returns second data word n (n = offset bits 7:3). `reg_rvalid` and `reg_rdata` appear one cycle after the read request.
- R6: A read at exactly offset 0x600 returns the first data word, and a read at exactly offset 0x700 returns the second data word, of mailbox number `reg_cpu`.
- R7: A read at offset 0x900 + 8*n returns the status of mailbox n. Exactly offset 0xB00 returns the status of mailbox `reg_cpu`. The status word has busy in bit 5, the source id in bits 4:0 and zero elsewhere.
- R8: A write at offset 0x900 + 8*n, or at exactly 0xB00 (mailbox `reg_cpu`), loads that mailbox's busy flag from write-data bit 5 and leaves its source and data unchanged.
- R9: An arriving interrupt is judged on the busy state before the current cycle's register write. A clear written in the same cycle as an interrupt for a busy mailbox does not let that interrupt in. An interrupt accepted into a free mailbox in the same cycle as a busy write to that mailbox leaves it busy with the new contents.
- R10: Writes to any offset other than the busy registers change nothing. Reads of offsets outside the ranges in R5 to R7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_vec | input | 6 | Vector posted for every accepted external interrupt |
| irq_req | input | 1 | Incoming interrupt request |
| irq_cpu | input | 5 | Target CPU of the request |
| irq_src | input | 5 | Source id of the request |
| irq_d0 | input | 64 | First data word of the request |
| irq_d1 | input | 64 | Second data word of the request |
| irq_ack | output | 1 | Request accepted this cycle (combinational) |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_cpu | input | 5 | CPU id of the requester |
| reg_wdata | input | 64 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 64 | Read data |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | CPU that receives the post |
| post_vec | output | 6 | Vector of the post |

## Verification
`irq_ack` is combinational, so it is sampled one time unit after the inputs change, in the same cycle as the request. The post, the updated mailbox contents and register read data are all due one cycle later, after the clock edge that registers them. The bench drives every input on the falling edge and checks the registered results on the following falling edge. A bench model applies the same-cycle priority of R9 when it computes what each later read must return. Random traffic is aimed at a few CPUs so that refusals and races between a clear and an arrival happen often, and directed steps place each race deliberately.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Register offsets are 12-bit byte offsets inside the block window
    localparam int OFS_W = 12;

    // Page (offset bits 11:8) of each region; software depends on these
    localparam logic [3:0] PG_DATA0   = 4'h4;
    localparam logic [3:0] PG_DATA1   = 4'h5;
    localparam logic [3:0] PG_OWN0    = 4'h6;
    localparam logic [3:0] PG_OWN1    = 4'h7;
    localparam logic [3:0] PG_STATUS  = 4'h9;
    localparam logic [3:0] PG_OWNSTAT = 4'hB;

    // Bit of the status word that holds the busy flag
    localparam int BUSY_POS = 5;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_D0_IDX,
        REG_D1_IDX,
        REG_D0_SELF,
        REG_D1_SELF,
        REG_STAT_IDX,
        REG_STAT_SELF
    } reg_sel_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int CPU_W = 5
) (
    input  logic [OFS_W-1:0] addr_i,
    input  logic [CPU_W-1:0] req_cpu_i,
    output reg_sel_e         sel_o,
    output logic [CPU_W-1:0] slot_o
);

    logic [3:0] page;
    logic       low_zero;

    assign page     = addr_i[OFS_W-1:8];
    assign low_zero = (addr_i[7:0] == 8'h00);

    always_comb begin
        sel_o  = REG_NONE;
        slot_o = addr_i[3 +: CPU_W];
        case (page)
            PG_DATA0:   sel_o = REG_D0_IDX;
            PG_DATA1:   sel_o = REG_D1_IDX;
            PG_STATUS:  sel_o = REG_STAT_IDX;
            PG_OWN0: begin
                if (low_zero) begin
                    sel_o  = REG_D0_SELF;
                    slot_o = req_cpu_i;
                end
            end
            PG_OWN1: begin
                if (low_zero) begin
                    sel_o  = REG_D1_SELF;
                    slot_o = req_cpu_i;
                end
            end
            PG_OWNSTAT: begin
                if (low_zero) begin
                    sel_o  = REG_STAT_SELF;
                    slot_o = req_cpu_i;
                end
            end
            default: sel_o = REG_NONE;
        endcase
    end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [DATA_W-1:0] d0_i,
    input  logic [DATA_W-1:0] d1_i,
    input  logic              sw_wr_i,
    input  logic              sw_busy_i,
    output logic              busy_o,
    output logic [SRC_W-1:0]  src_o,
    output logic [DATA_W-1:0] d0_o,
    output logic [DATA_W-1:0] d1_o
);

    typedef struct packed {
        logic              busy;
        logic [SRC_W-1:0]  src;
        logic [DATA_W-1:0] d0;
        logic [DATA_W-1:0] d1;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.busy = 1'b1;
            st_d.src  = src_i;
            st_d.d0   = d0_i;
            st_d.d1   = d1_i;
        end else if (sw_wr_i) begin
            st_d.busy = sw_busy_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign src_o  = st_q.src;
    assign d0_o   = st_q.d0;
    assign d1_o   = st_q.d1;

    // R3
    take_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> !st_q.busy);

    // R2
    take_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (st_q.busy && st_q.src == $past(src_i)
                    && st_q.d0 == $past(d0_i) && st_q.d1 == $past(d1_i)));

    // R8
    sw_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !take_i) |=> (st_q.busy == $past(sw_busy_i)));

    // R3
    contents_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ($stable(st_q.src) && $stable(st_q.d0) && $stable(st_q.d1)));

endmodule

// File: rtl/mbx_post.sv
module mbx_post #(
    parameter int CPU_W = 5,
    parameter int VEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [CPU_W-1:0] cpu_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             valid_o,
    output logic [CPU_W-1:0] cpu_o,
    output logic [VEC_W-1:0] vec_o
);

    typedef struct packed {
        logic             valid;
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } post_t;

    post_t pst_d, pst_q;

    always_comb begin
        pst_d       = pst_q;
        pst_d.valid = fire_i;
        if (fire_i) begin
            pst_d.cpu = cpu_i;
            pst_d.vec = vec_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pst_q <= '0;
        else        pst_q <= pst_d;
    end

    assign valid_o = pst_q.valid;
    assign cpu_o   = pst_q.cpu;
    assign vec_o   = pst_q.vec;

    // R4
    post_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q.valid && !fire_i) |=> !pst_q.valid);

endmodule

// File: rtl/ext_irq_mailbox.sv
module ext_irq_mailbox
    import mbx_pkg::*;
#(
    parameter int CPU_N  = 32,
    parameter int DATA_W = 64,
    parameter int SRC_W  = 5,
    parameter int VEC_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [VEC_W-1:0]         ext_vec,
    input  logic                     irq_req,
    input  logic [$clog2(CPU_N)-1:0] irq_cpu,
    input  logic [SRC_W-1:0]         irq_src,
    input  logic [DATA_W-1:0]        irq_d0,
    input  logic [DATA_W-1:0]        irq_d1,
    output logic                     irq_ack,
    input  logic                     reg_valid,
    input  logic                     reg_write,
    input  logic [OFS_W-1:0]         reg_addr,
    input  logic [$clog2(CPU_N)-1:0] reg_cpu,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic                     reg_rvalid,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     post_valid,
    output logic [$clog2(CPU_N)-1:0] post_cpu,
    output logic [VEC_W-1:0]         post_vec
);

    localparam int CPU_W = $clog2(CPU_N);

    logic [CPU_N-1:0]  busy_a;
    logic [SRC_W-1:0]  src_a [CPU_N];
    logic [DATA_W-1:0] d0_a  [CPU_N];
    logic [DATA_W-1:0] d1_a  [CPU_N];

    reg_sel_e          dec_sel;
    logic [CPU_W-1:0]  dec_slot;
    logic              accept;
    logic              sw_busy_wr;
    logic              wdata_unused;

    assign wdata_unused = ^{reg_wdata[DATA_W-1:BUSY_POS+1], reg_wdata[BUSY_POS-1:0]};

    mbx_decode #(.CPU_W(CPU_W)) u_dec (
        .addr_i    (reg_addr),
        .req_cpu_i (reg_cpu),
        .sel_o     (dec_sel),
        .slot_o    (dec_slot)
    );

    // Arrival is judged on registered busy, before any write this cycle
    assign accept  = irq_req && !busy_a[irq_cpu];
    assign irq_ack = accept;

    assign sw_busy_wr = reg_valid && reg_write &&
                        (dec_sel == REG_STAT_IDX || dec_sel == REG_STAT_SELF);

    for (genvar g = 0; g < CPU_N; g++) begin : g_slot
        logic take_g;
        logic wr_g;
        assign take_g = accept && (irq_cpu == CPU_W'(g));
        assign wr_g   = sw_busy_wr && (dec_slot == CPU_W'(g));
        mbx_slot #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .take_i    (take_g),
            .src_i     (irq_src),
            .d0_i      (irq_d0),
            .d1_i      (irq_d1),
            .sw_wr_i   (wr_g),
            .sw_busy_i (reg_wdata[BUSY_POS]),
            .busy_o    (busy_a[g]),
            .src_o     (src_a[g]),
            .d0_o      (d0_a[g]),
            .d1_o      (d1_a[g])
        );
    end

    mbx_post #(.CPU_W(CPU_W), .VEC_W(VEC_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (accept),
        .cpu_i   (irq_cpu),
        .vec_i   (ext_vec),
        .valid_o (post_valid),
        .cpu_o   (post_cpu),
        .vec_o   (post_vec)
    );

    // Read path: one registered stage
    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        stat_word                = '0;
        stat_word[BUSY_POS]      = busy_a[dec_slot];
        stat_word[SRC_W-1:0]     = src_a[dec_slot];
    end

    always_comb begin
        rd_d        = '0;
        rd_d.rvalid = reg_valid && !reg_write;
        if (reg_valid && !reg_write) begin
            case (dec_sel)
                REG_D0_IDX, REG_D0_SELF:     rd_d.rdata = d0_a[dec_slot];
                REG_D1_IDX, REG_D1_SELF:     rd_d.rdata = d1_a[dec_slot];
                REG_STAT_IDX, REG_STAT_SELF: rd_d.rdata = stat_word;
                default:                     rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rvalid = rd_q.rvalid;
    assign reg_rdata  = rd_q.rdata;

    // R4
    post_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (post_valid && post_cpu == $past(irq_cpu) && post_vec == $past(ext_vec)));

    // R3
    refused_no_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> !post_valid);

    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> irq_req);

    // R5
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> reg_rvalid);

    // R10
    write_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> (!reg_rvalid && reg_rdata == '0));

endmodule

// File: tb/sim_ext_irq_mailbox.sv
module sim_ext_irq_mailbox;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_vec = '0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_cpu = '0, irq_src = '0;
    logic [63:0] irq_d0 = '0, irq_d1 = '0;
    logic        irq_ack;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [4:0]  reg_cpu = '0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [63:0] reg_rdata;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of the mailboxes
    bit          m_busy [32];
    logic [4:0]  m_src  [32];
    logic [63:0] m_d0   [32];
    logic [63:0] m_d1   [32];

    always #(CLK_P/2) clk = ~clk;

    ext_irq_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .ext_vec(ext_vec),
        .irq_req(irq_req), .irq_cpu(irq_cpu), .irq_src(irq_src),
        .irq_d0(irq_d0), .irq_d1(irq_d1), .irq_ack(irq_ack),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
        .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] stat_of(input int i);
        logic [63:0] w;
        w = '0;
        w[5] = m_busy[i];
        w[4:0] = m_src[i];
        return w;
    endfunction

    function automatic logic [63:0] exp_read(input logic [11:0] a, input logic [4:0] c);
        case (a[11:8])
            4'h4: return m_d0[a[7:3]];
            4'h5: return m_d1[a[7:3]];
            4'h9: return stat_of(a[7:3]);
            4'h6: return (a[7:0] == 0) ? m_d0[c] : 64'd0;
            4'h7: return (a[7:0] == 0) ? m_d1[c] : 64'd0;
            4'hB: return (a[7:0] == 0) ? stat_of(c) : 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        case (a[11:8])
            4'h4, 4'h5: return "R5 indexed data read";
            4'h6, 4'h7: return (a[7:0] == 0) ? "R6 own data read" : "R10 unmapped read";
            4'h9: return "R7 status read";
            4'hB: return (a[7:0] == 0) ? "R7 own status read" : "R10 unmapped read";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // One cycle of stimulus, driven at a falling edge, checked at the next one
    task automatic step(input bit ir, input logic [4:0] icpu, input logic [4:0] isrc,
                        input logic [63:0] a, input logic [63:0] b,
                        input bit rv, input bit rw, input logic [11:0] ad,
                        input logic [4:0] rc, input logic [63:0] wd, input logic [5:0] vec);
        bit e_ack;
        bit is_rd;
        logic [63:0] e_rd;
        int wslot;
        irq_req = ir; irq_cpu = icpu; irq_src = isrc; irq_d0 = a; irq_d1 = b;
        reg_valid = rv; reg_write = rw; reg_addr = ad; reg_cpu = rc; reg_wdata = wd;
        ext_vec = vec;
        #1;
        e_ack = ir && !m_busy[icpu];
        if (ir) chk(irq_ack == e_ack, e_ack ? "R2 accept" : "R3 refuse", 64'(irq_ack), 64'(e_ack));
        else    chk(irq_ack == 1'b0, "R1 no ack without request", 64'(irq_ack), 64'd0);
        is_rd = rv && !rw;
        e_rd  = is_rd ? exp_read(ad, rc) : 64'd0;
        @(posedge clk);
        // model update (R8, R9)
        wslot = -1;
        if (rv && rw) begin
            if (ad[11:8] == 4'h9) wslot = int'(ad[7:3]);
            else if (ad == 12'hB00) wslot = int'(rc);
        end
        if (wslot >= 0 && !(e_ack && int'(icpu) == wslot)) m_busy[wslot] = wd[5];
        if (e_ack) begin
            m_busy[icpu] = 1'b1; m_src[icpu] = isrc; m_d0[icpu] = a; m_d1[icpu] = b;
        end
        @(negedge clk);
        chk(post_valid == e_ack, "R4 post strobe", 64'(post_valid), 64'(e_ack));
        if (e_ack) begin
            chk(post_cpu == icpu, "R4 post cpu", 64'(post_cpu), 64'(icpu));
            chk(post_vec == vec, "R4 post vector", 64'(post_vec), 64'(vec));
        end
        chk(reg_rvalid == is_rd, "R5 read valid timing", 64'(reg_rvalid), 64'(is_rd));
        if (is_rd) chk(reg_rdata == e_rd, read_tag(ad), reg_rdata, e_rd);
        irq_req = 1'b0; reg_valid = 1'b0;
    endtask

    task automatic rd(input logic [11:0] ad, input logic [4:0] rc);
        step(1'b0, 5'd0, 5'd0, 64'd0, 64'd0, 1'b1, 1'b0, ad, rc, 64'd0, 6'd0);
    endtask

    task automatic wr(input logic [11:0] ad, input logic [4:0] rc, input logic [63:0] wd);
        step(1'b0, 5'd0, 5'd0, 64'd0, 64'd0, 1'b1, 1'b1, ad, rc, wd, 6'd0);
    endtask

    function automatic logic [4:0] pick_cpu();
        return ($urandom % 5 == 0) ? 5'd31 : 5'($urandom % 4);
    endfunction

    function automatic logic [11:0] pick_addr(input logic [4:0] c);
        case ($urandom % 7)
            0: return {4'h4, c, 3'b000};
            1: return {4'h5, c, 3'b000};
            2: return 12'h600;
            3: return 12'h700;
            4: return {4'h9, c, 3'b000};
            5: return 12'hB00;
            default: return 12'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < 32; i++) begin
            m_busy[i] = 1'b0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(post_valid == 1'b0, "R1 post low after reset", 64'(post_valid), 64'd0);
        rd(12'h900, 5'd0);
        rd(12'h9F8, 5'd0);
        rd(12'h4F8, 5'd0);
        rd(12'h500, 5'd0);
        rd(12'hB00, 5'd7);

        // R2 accept into mailbox 31, then indexed reads (R5, R7)
        step(1'b1, 5'd31, 5'h1F, 64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_A5A5_5A5A,
             1'b0, 1'b0, 12'h0, 5'd0, 64'd0, 6'h2A);
        rd(12'h4F8, 5'd0);
        rd(12'h5F8, 5'd0);
        rd(12'h9F8, 5'd0);
        // R3 refuse while busy; contents unchanged
        step(1'b1, 5'd31, 5'h03, 64'h1, 64'h2, 1'b0, 1'b0, 12'h0, 5'd0, 64'd0, 6'h11);
        rd(12'h4F8, 5'd0);
        // R6 own data aliases
        rd(12'h600, 5'd31);
        rd(12'h700, 5'd31);
        // R9 clear via own alias in same cycle as new arrival: refused
        step(1'b1, 5'd31, 5'h04, 64'h3, 64'h4, 1'b1, 1'b1, 12'hB00, 5'd31, 64'd0, 6'h05);
        rd(12'hB00, 5'd31);
        step(1'b1, 5'd31, 5'h04, 64'h3, 64'h4, 1'b0, 1'b0, 12'h0, 5'd0, 64'd0, 6'h05);
        // R9 arrival into free mailbox 2 with simultaneous busy write of 0
        step(1'b1, 5'd2, 5'h09, 64'h55, 64'h66, 1'b1, 1'b1, 12'h910, 5'd0, 64'd0, 6'h3F);
        rd(12'h910, 5'd0);
        // R8 software sets busy, then interrupt refused; clear by index
        wr(12'h918, 5'd0, 64'h20);
        step(1'b1, 5'd3, 5'h01, 64'h7, 64'h8, 1'b0, 1'b0, 12'h0, 5'd0, 64'd0, 6'h01);
        wr(12'h918, 5'd0, 64'hFFFF_FFFF_FFFF_FFDF);
        rd(12'h918, 5'd0);
        // R10 writes elsewhere ignored; unmapped reads zero
        wr(12'h410, 5'd0, 64'hABCD);
        wr(12'h600, 5'd2, 64'hABCD);
        rd(12'h410, 5'd0);
        rd(12'h608, 5'd2);
        rd(12'hA00, 5'd2);
        rd(12'hB08, 5'd2);

        // constrained random traffic
        for (int k = 0; k < 1500; k++) begin
            logic [4:0]  rc;
            logic [63:0] wd;
            rc = pick_cpu();
            wd = {$urandom, $urandom};
            step(($urandom % 2) == 1, pick_cpu(), 5'($urandom), {$urandom, $urandom},
                 {$urandom, $urandom}, ($urandom % 4) != 0, ($urandom % 3) == 0,
                 pick_addr(pick_cpu()), rc, wd, 6'($urandom));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule